// File: doc/BRIEF.md
# PC-Localized History-Buffer Stride Prefetcher

This block watches the stream of cache misses. Each miss is tagged with the program counter of the load that caused it. A small direct-mapped index table, selected by the low bits of that program counter, holds a pointer to the newest history record that the same load wrote. Each history record sits in a shared circular buffer and links back to the load's previous record. Walking these links recovers the load's recent miss addresses.

On every accepted miss the block first appends the new record. It then walks back to the two previous misses of the same load and compares the latest two address deltas. When the two deltas are equal and not zero, it emits a burst of prefetch addresses, one per cycle, stepping forward by the detected delta from the current miss. Every table or buffer read takes one cycle. While the walk or the burst runs, the block holds off new misses.

The caller passes only the low `PC_W` bits of the load address. The bits above the index form a partial tag, so two loads that share low bits can be mistaken for one another.

Top module: `stride_hist_prefetch`

## Requirements
- R1: After reset the block is ready (`miss_ready`=1), `pf_valid` is 0, and no load has any history, so the first miss of any load issues no prefetch.
- R2: The index-table slot is `miss_pc[IDX_W-1:0]`, and `miss_pc[PC_W-1:IDX_W]` is stored as its tag. A miss whose tag differs from the stored tag is treated as having no history, and it takes over that slot.
- R3: The history of each load is linked separately. Misses from other loads that fall between two misses of a load do not break that load's chain.
- R4: Let n be the current miss address, a1 the load's previous miss address and a2 the one before it. If n−a1 equals a1−a2 and that stride s is not zero, the block issues exactly DEGREE prefetches, n+s, n+2s, …, n+DEGREE·s, one per cycle. The first one appears in the third cycle after the accepting edge.
- R5: If the two latest strides differ, no prefetch is issued.
- R6: A stride of zero never produces a prefetch.
- R7: With fewer than two earlier misses of the same load on record, no prefetch is issued.
- R8: The buffer keeps the last DEPTH records (16 by default) in FIFO order. A record counts as lost once DEPTH newer misses have been written, the current one included. A link to a lost record ends the walk, and nothing is prefetched.
- R9: `miss_ready` falls for the cycles after an accept. It returns high one cycle after the accept when the index table misses, after two cycles when the walk ends at the first predecessor, after three cycles when it ends at the second predecessor or the strides fail, and after 3+DEGREE cycles after a burst. A `miss_valid` held high while `miss_ready` is low is ignored.
- R10: Address and stride arithmetic wraps modulo 2^ADDR_W, so descending strides predict descending addresses across zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | A miss event is offered |
| miss_ready | output | 1 | The block accepts a miss on this cycle |
| miss_pc | input | PC_W | Low program-counter bits of the missing load |
| miss_addr | input | ADDR_W | Miss address |
| pf_valid | output | 1 | A prefetch address is presented |
| pf_addr | output | ADDR_W | Prefetch address |

## Verification
The hardest case to reach is a link that points at a record the FIFO has just overwritten. From the ports this can only be reached by counting misses exactly. The stimulus gives one load two misses, then inserts unrelated misses before that load's third miss: 13 fillers in one run, 14 in another. The second predecessor survives in the first run and is lost in the second. A behavioural model tracks the number of every miss. It predicts `miss_ready`, `pf_valid` and `pf_addr` on each clock, including during stretches where junk misses are held on the input while the block is busy.

// File: rtl/shp_pkg.sv
// Shared definitions for the history-buffer stride prefetcher.
// Assumes nothing beyond IEEE 1800-2017 packages.
package shp_pkg;

    // Walk phases: one table or buffer access per phase.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INDEX = 3'd1,
        ST_WALK1 = 3'd2,
        ST_WALK2 = 3'd3,
        ST_ISSUE = 3'd4
    } walk_state_e;

endpackage

// File: rtl/shp_index_table.sv
// Direct-mapped table from low PC bits to the newest history sequence
// number of that load. The upper PC bits are kept as a partial tag.
// Assumes lk_pc is held steady for the cycle after an update.
module shp_index_table #(
    parameter int PC_W  = 12,
    parameter int IDX_W = 4,
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_hit,
    output logic [SEQ_W-1:0] lk_head,
    input  logic             upd_en,
    input  logic [SEQ_W-1:0] upd_seq
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = PC_W - IDX_W;

    logic             ent_valid [ENTRIES];
    logic [TAG_W-1:0] ent_tag   [ENTRIES];
    logic [SEQ_W-1:0] ent_head  [ENTRIES];

    logic [IDX_W-1:0] slot;
    logic [TAG_W-1:0] key;

    assign slot = lk_pc[IDX_W-1:0];
    assign key  = lk_pc[PC_W-1:IDX_W];

    // Lookup: valid entry with matching partial tag.
    always_comb begin
        lk_hit  = ent_valid[slot] && (ent_tag[slot] == key);
        lk_head = ent_head[slot];
    end

    // Valid bits: cleared by reset, set on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_valid[i] <= 1'b0;
            end
        end else if (upd_en) begin
            ent_valid[slot] <= 1'b1;
        end
    end

    // Tag and head pointer payload: written on update.
    always_ff @(posedge clk) begin
        if (upd_en) begin
            ent_tag[slot]  <= key;
            ent_head[slot] <= upd_seq;
        end
    end

    // An update is visible as a hit on the very next lookup.
    p_update_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (lk_hit && lk_head == $past(upd_seq)));

endmodule

// File: rtl/shp_history_buf.sv
// Circular history of miss records. Each record holds its miss address,
// its own sequence number and a link to the same load's previous record.
// A read is "fresh" only if the slot still holds the requested sequence.
// Assumes SEQ_W > SLOT_W so overwritten slots are told apart.
module shp_history_buf #(
    parameter int ADDR_W = 32,
    parameter int SLOT_W = 4,
    parameter int SEQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEQ_W-1:0]  wr_seq,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SEQ_W-1:0]  wr_prev,
    input  logic              wr_prev_ok,
    input  logic [SEQ_W-1:0]  rd_seq,
    output logic              rd_fresh,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [SEQ_W-1:0]  rd_prev,
    output logic              rd_prev_ok
);
    localparam int DEPTH = 1 << SLOT_W;

    logic              rec_valid   [DEPTH];
    logic [SEQ_W-1:0]  rec_seq     [DEPTH];
    logic [ADDR_W-1:0] rec_addr    [DEPTH];
    logic [SEQ_W-1:0]  rec_prev    [DEPTH];
    logic              rec_prev_ok [DEPTH];

    logic [SLOT_W-1:0] wslot;
    logic [SLOT_W-1:0] rslot;

    assign wslot = wr_seq[SLOT_W-1:0];
    assign rslot = rd_seq[SLOT_W-1:0];

    // Read port: freshness compares the stored sequence number.
    always_comb begin
        rd_fresh   = rec_valid[rslot] && (rec_seq[rslot] == rd_seq);
        rd_addr    = rec_addr[rslot];
        rd_prev    = rec_prev[rslot];
        rd_prev_ok = rec_prev_ok[rslot];
    end

    // Valid bits: cleared by reset, set when a slot is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                rec_valid[i] <= 1'b0;
            end
        end else if (wr_en) begin
            rec_valid[wslot] <= 1'b1;
        end
    end

    // Record payload: the oldest slot is overwritten in FIFO order.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            rec_seq[wslot]     <= wr_seq;
            rec_addr[wslot]    <= wr_addr;
            rec_prev[wslot]    <= wr_prev;
            rec_prev_ok[wslot] <= wr_prev_ok;
        end
    end

    // A record just written is readable as fresh under its own number.
    p_written_is_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rec_valid[$past(wslot)] && rec_seq[$past(wslot)] == $past(wr_seq)));

endmodule

// File: rtl/shp_walk_ctrl.sv
// Sequencer: accepts a miss, appends its record, walks two links back,
// compares the two latest strides and issues DEGREE prefetches on a match.
// Assumes one access per table per phase; misses are refused while busy.
module shp_walk_ctrl
    import shp_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int ADDR_W = 32,
    parameter int SEQ_W  = 16,
    parameter int DEGREE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [PC_W-1:0]   miss_pc,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic [PC_W-1:0]   it_pc,
    input  logic              it_hit,
    input  logic [SEQ_W-1:0]  it_head,
    output logic              it_upd_en,
    output logic [SEQ_W-1:0]  it_upd_seq,
    output logic              hb_wr_en,
    output logic [SEQ_W-1:0]  hb_wr_seq,
    output logic [ADDR_W-1:0] hb_wr_addr,
    output logic [SEQ_W-1:0]  hb_wr_prev,
    output logic              hb_wr_prev_ok,
    output logic [SEQ_W-1:0]  hb_rd_seq,
    input  logic              hb_rd_fresh,
    input  logic [ADDR_W-1:0] hb_rd_addr,
    input  logic [SEQ_W-1:0]  hb_rd_prev,
    input  logic              hb_rd_prev_ok,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    localparam int CNT_W = (DEGREE > 1) ? $clog2(DEGREE) : 1;
    localparam int RUN_W = $clog2(DEGREE + 1) + 1;

    walk_state_e       state_q;
    logic [PC_W-1:0]   pc_q;
    logic [ADDR_W-1:0] n_q;
    logic [ADDR_W-1:0] a1_q;
    logic [SEQ_W-1:0]  link_q;
    logic [SEQ_W-1:0]  seq_q;
    logic [ADDR_W-1:0] stride_q;
    logic [ADDR_W-1:0] nxt_q;
    logic [CNT_W-1:0]  cnt_q;

    logic [ADDR_W-1:0] stride_new;
    logic [ADDR_W-1:0] stride_old;
    logic              burst_last;

    // Table port wiring driven from the current phase.
    always_comb begin
        miss_ready    = (state_q == ST_IDLE);
        pf_valid      = (state_q == ST_ISSUE);
        pf_addr       = nxt_q;
        it_pc         = pc_q;
        it_upd_en     = (state_q == ST_INDEX);
        it_upd_seq    = seq_q;
        hb_wr_en      = (state_q == ST_INDEX);
        hb_wr_seq     = seq_q;
        hb_wr_addr    = n_q;
        hb_wr_prev    = it_head;
        hb_wr_prev_ok = it_hit;
        hb_rd_seq     = link_q;
    end

    // Stride comparison for the second walk step.
    always_comb begin
        stride_new = n_q - a1_q;
        stride_old = a1_q - hb_rd_addr;
        burst_last = (cnt_q == CNT_W'(DEGREE - 1));
    end

    // Phase sequencing and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            seq_q    <= '0;
            pc_q     <= '0;
            n_q      <= '0;
            a1_q     <= '0;
            link_q   <= '0;
            stride_q <= '0;
            nxt_q    <= '0;
            cnt_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (miss_valid) begin
                        pc_q    <= miss_pc;
                        n_q     <= miss_addr;
                        state_q <= ST_INDEX;
                    end
                end
                ST_INDEX: begin
                    seq_q   <= seq_q + 1'b1;
                    link_q  <= it_head;
                    state_q <= it_hit ? ST_WALK1 : ST_IDLE;
                end
                ST_WALK1: begin
                    if (hb_rd_fresh && hb_rd_prev_ok) begin
                        a1_q    <= hb_rd_addr;
                        link_q  <= hb_rd_prev;
                        state_q <= ST_WALK2;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_WALK2: begin
                    if (hb_rd_fresh && (stride_new == stride_old) && (stride_new != '0)) begin
                        stride_q <= stride_new;
                        nxt_q    <= n_q + stride_new;
                        cnt_q    <= '0;
                        state_q  <= ST_ISSUE;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_ISSUE: begin
                    nxt_q <= nxt_q + stride_q;
                    cnt_q <= cnt_q + 1'b1;
                    if (burst_last) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Checker counter: length of the current run of prefetch cycles.
    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= pf_valid ? run_q + 1'b1 : '0;
        end
    end

    p_accept_then_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> !miss_ready);

    p_burst_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (run_q < RUN_W'(DEGREE)));

    p_step_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && $past(pf_valid)) |-> (pf_addr != $past(pf_addr)));

    p_burst_after_walk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> ($past(state_q) == ST_WALK2));

    p_busy_while_issuing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> !miss_ready);

endmodule

// File: rtl/stride_hist_prefetch.sv
// Top: PC-localized stride prefetcher over a shared miss-history FIFO.
// Wires the index table, the history buffer and the walk sequencer.
// Assumes the caller supplies only the low PC_W program-counter bits.
module stride_hist_prefetch #(
    parameter int PC_W   = 12,
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 32,
    parameter int SLOT_W = 4,
    parameter int SEQ_W  = 16,
    parameter int DEGREE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [PC_W-1:0]   miss_pc,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    logic [PC_W-1:0]   it_pc;
    logic              it_hit;
    logic [SEQ_W-1:0]  it_head;
    logic              it_upd_en;
    logic [SEQ_W-1:0]  it_upd_seq;
    logic              hb_wr_en;
    logic [SEQ_W-1:0]  hb_wr_seq;
    logic [ADDR_W-1:0] hb_wr_addr;
    logic [SEQ_W-1:0]  hb_wr_prev;
    logic              hb_wr_prev_ok;
    logic [SEQ_W-1:0]  hb_rd_seq;
    logic              hb_rd_fresh;
    logic [ADDR_W-1:0] hb_rd_addr;
    logic [SEQ_W-1:0]  hb_rd_prev;
    logic              hb_rd_prev_ok;

    shp_index_table #(
        .PC_W (PC_W),
        .IDX_W(IDX_W),
        .SEQ_W(SEQ_W)
    ) index_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_pc  (it_pc),
        .lk_hit (it_hit),
        .lk_head(it_head),
        .upd_en (it_upd_en),
        .upd_seq(it_upd_seq)
    );

    shp_history_buf #(
        .ADDR_W(ADDR_W),
        .SLOT_W(SLOT_W),
        .SEQ_W (SEQ_W)
    ) hist_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (hb_wr_en),
        .wr_seq    (hb_wr_seq),
        .wr_addr   (hb_wr_addr),
        .wr_prev   (hb_wr_prev),
        .wr_prev_ok(hb_wr_prev_ok),
        .rd_seq    (hb_rd_seq),
        .rd_fresh  (hb_rd_fresh),
        .rd_addr   (hb_rd_addr),
        .rd_prev   (hb_rd_prev),
        .rd_prev_ok(hb_rd_prev_ok)
    );

    shp_walk_ctrl #(
        .PC_W  (PC_W),
        .ADDR_W(ADDR_W),
        .SEQ_W (SEQ_W),
        .DEGREE(DEGREE)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_valid   (miss_valid),
        .miss_ready   (miss_ready),
        .miss_pc      (miss_pc),
        .miss_addr    (miss_addr),
        .it_pc        (it_pc),
        .it_hit       (it_hit),
        .it_head      (it_head),
        .it_upd_en    (it_upd_en),
        .it_upd_seq   (it_upd_seq),
        .hb_wr_en     (hb_wr_en),
        .hb_wr_seq    (hb_wr_seq),
        .hb_wr_addr   (hb_wr_addr),
        .hb_wr_prev   (hb_wr_prev),
        .hb_wr_prev_ok(hb_wr_prev_ok),
        .hb_rd_seq    (hb_rd_seq),
        .hb_rd_fresh  (hb_rd_fresh),
        .hb_rd_addr   (hb_rd_addr),
        .hb_rd_prev   (hb_rd_prev),
        .hb_rd_prev_ok(hb_rd_prev_ok),
        .pf_valid     (pf_valid),
        .pf_addr      (pf_addr)
    );

endmodule

// File: tb/stride_hist_prefetch_tb.sv
// Bench: behavioural model (miss-number lists, per-slot head numbers)
// predicting ready, prefetch valid and prefetch address on every clock.
module stride_hist_prefetch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEG        = 4;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        miss_valid;
    logic        miss_ready;
    logic [11:0] miss_pc;
    logic [31:0] miss_addr;
    logic        pf_valid;
    logic [31:0] pf_addr;

    int n_checks = 0;
    int n_bad    = 0;

    // Model state: one entry per accepted miss, indexed by its number.
    int          total = 0;
    logic [31:0] addr_of [$];
    int          prev_of [$];
    bit          it_valid [16];
    logic [7:0]  it_tag   [16];
    int          it_head  [16];

    always #(CLK_PERIOD / 2) clk = ~clk;

    stride_hist_prefetch dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .miss_valid(miss_valid),
        .miss_ready(miss_ready),
        .miss_pc   (miss_pc),
        .miss_addr (miss_addr),
        .pf_valid  (pf_valid),
        .pf_addr   (pf_addr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Offer one miss at a negedge with the block idle; follow it to idle.
    task automatic send(input logic [11:0] pc, input logic [31:0] a,
                        input string req, input bit junk);
        int k, p1, p2, fin;
        bit hit;
        logic [3:0]  idx;
        logic [7:0]  tg;
        logic [31:0] s1, s2, e;
        k = total; idx = pc[3:0]; tg = pc[11:4];
        p1 = (it_valid[idx] && it_tag[idx] == tg) ? it_head[idx] : -1;
        hit = 0; s1 = '0;
        if (p1 < 0) fin = 1;
        else if (p1 <= k - DEPTH || prev_of[p1] < 0) fin = 2;
        else begin
            p2 = prev_of[p1];
            if (p2 <= k - DEPTH) fin = 3;
            else begin
                s1 = a - addr_of[p1];
                s2 = addr_of[p1] - addr_of[p2];
                if (s1 == s2 && s1 != 0) begin hit = 1; fin = 3 + DEG; end
                else fin = 3;
            end
        end
        addr_of.push_back(a); prev_of.push_back(p1);
        it_valid[idx] = 1; it_tag[idx] = tg; it_head[idx] = k;
        total++;
        check(miss_ready === 1'b1, "R9", "ready before offer", {31'd0, miss_ready}, 32'd1);
        miss_valid = 1'b1; miss_pc = pc; miss_addr = a;
        for (int j = 0; j <= fin; j++) begin
            @(negedge clk);
            if (j == fin || !junk) miss_valid = 1'b0;
            else begin miss_pc = ~pc; miss_addr = a ^ 32'h5a5a_0000; end
            check(miss_ready === (j == fin), "R9", "ready timing",
                  {31'd0, miss_ready}, {31'd0, (j == fin)});
            if (hit && j >= 3 && j <= 2 + DEG) begin
                e = a + s1 * 32'(j - 2);
                check(pf_valid === 1'b1, "R4", "prefetch valid", {31'd0, pf_valid}, 32'd1);
                check(pf_addr === e, "R4", "prefetch address", pf_addr, e);
            end else begin
                check(pf_valid === 1'b0, req, "no prefetch", {31'd0, pf_valid}, 32'd0);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        logic [11:0] rpc [6];
        logic [31:0] rbase [6];
        logic [31:0] rstride [6];
        for (int i = 0; i < 16; i++) begin it_valid[i] = 0; it_tag[i] = '0; it_head[i] = 0; end
        rst_n = 1'b0; miss_valid = 1'b0; miss_pc = '0; miss_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(miss_ready === 1'b1, "R1", "ready after reset", {31'd0, miss_ready}, 32'd1);
        check(pf_valid === 1'b0, "R1", "pf idle after reset", {31'd0, pf_valid}, 32'd0);
        send(12'h011, 32'h1000, "R1", 0);
        // R7: only one predecessor
        send(12'h011, 32'h1040, "R7", 0);
        // R4: constant stride, then R5: broken stride
        send(12'h011, 32'h1080, "R4", 0);
        send(12'h011, 32'h10a0, "R5", 0);
        // R6: zero stride
        send(12'h022, 32'h500, "R6", 0);
        send(12'h022, 32'h500, "R6", 0);
        send(12'h022, 32'h500, "R6", 1);
        // R10: descending stride across zero
        send(12'h033, 32'h100, "R10", 0);
        send(12'h033, 32'h080, "R10", 0);
        send(12'h033, 32'h000, "R10", 0);
        // R3: interleaved loads, junk held during busy cycles (R9)
        for (int i = 0; i < 4; i++) begin
            send(12'h044, 32'h8000 + 32'(i * 8), "R3", 1);
            send(12'h055, 32'h4000 + 32'(i * 256), "R3", 1);
        end
        // R2: same slot, different partial tag
        send(12'h016, 32'h2000, "R2", 0);
        send(12'h016, 32'h2010, "R2", 0);
        send(12'h026, 32'h2020, "R2", 0);
        send(12'h016, 32'h2020, "R2", 0);
        send(12'h016, 32'h2030, "R2", 0);
        send(12'h016, 32'h2040, "R2", 0);
        // R8: 13 fillers keep both predecessors; 14 lose the oldest
        send(12'h007, 32'h9000, "R8", 0);
        send(12'h007, 32'h9040, "R8", 0);
        for (int i = 0; i < 13; i++) send(12'h00a, 32'h300 * 32'(i + 1), "R8", 0);
        send(12'h007, 32'h9080, "R8", 0);
        send(12'h00b, 32'h7000, "R8", 0);
        send(12'h00b, 32'h7100, "R8", 0);
        for (int i = 0; i < 14; i++) send(12'h00c, 32'h40 * 32'(i + 1), "R8", 0);
        send(12'h00b, 32'h7200, "R8", 0);
        // Mixed traffic with slot aliasing and stride changes
        rpc[0] = 12'h101; rpc[1] = 12'h202; rpc[2] = 12'h303;
        rpc[3] = 12'h404; rpc[4] = 12'h514; rpc[5] = 12'h625;
        for (int i = 0; i < 6; i++) begin
            rbase[i] = 32'h10000 * 32'(i + 1); rstride[i] = 32'h40;
        end
        for (int i = 0; i < 300; i++) begin
            int r;
            r = int'($urandom % 6);
            if ($urandom % 8 == 0) rstride[r] = 32'(($urandom % 5) * 64) - 32'd128;
            rbase[r] = rbase[r] + rstride[r];
            send(rpc[r], rbase[r], "R4", ($urandom % 2) == 1);
        end
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule